// File: doc/BRIEF.md
# Multi-mode match timer

This block is a single down/up counter that serves one of five jobs at a time. With `wide_mode` high it is a full-width real-time counter that counts up every clock and raises its status flag when the count equals the full match value. With `wide_mode` low only the lower half of the counter is used. `mode` then selects one of four jobs: one-shot countdown, periodic countdown, PWM generation or counting edges on an input pin.

Software reaches four words through a simple register port: the interval load value, the match value, the prescale value and the live count. The match value is read differently in each job. In real-time-clock mode it is a full-width compare value. In PWM mode it is the duty threshold. In edge-count mode it is the count at which counting stops. The prescaler divides only the one-shot and periodic countdowns.

Top module: `mm_match_timer`

## Requirements
- R1: After reset the load word reads 0, the prescale word reads 0, the count reads 0, and `flag` and `pwm_out` are low. The match word reads all ones of the active width: lower half only when `wide_mode` is low during reset, full width when it is high.
- R2: Register addresses are 0 = load, 1 = match, 2 = prescale, 3 = count (read) / status (write). When `wide_mode` is low, the upper half of the match word reads zero and has no effect on any compare.
- R3: The prescale word keeps the low PS_W bits of the last value written. All other bits read zero.
- R4: One-shot (`mode` 00, narrow): writing the load word sets the count. The count drops by one per prescaled tick. `flag` sets on the tick that brings it to zero. It then stays at zero, so `flag` rises (load)*(prescale+1) clocks after `run` is raised.
- R5: Periodic (`mode` 01, narrow): on a tick at count zero, the count reloads from the load word and `flag` sets. Successive flag events are (load+1)*(prescale+1) clocks apart.
- R6: The prescale value affects only the one-shot and periodic modes. PWM, edge-count and real-time-clock modes advance without division.
- R7: Real-time clock (`wide_mode` high, `mode` ignored): the count rises by one every running clock from the value written to the load word. `flag` sets at the clock edge where the full-width count equals the full-width match word.
- R8: PWM (`mode` 10, narrow): the count falls by one every clock and reloads from the load word after zero. `pwm_out` is high exactly while the count is above the match value. Over each period of load+1 clocks it is therefore high for load-match clocks (0 when match >= load).
- R9: Edge count (`mode` 11, narrow): each rising edge of the two-flop-synchronised `edge_in` lowers the count by one until it equals the match value, where it stops. Exactly load-match edges are counted, and `flag` sets when the match value is reached.
- R10: `flag` is sticky. A write to address 3 with bit 0 set clears it, a write with bit 0 clear leaves it set, and a new flag event in the same cycle wins over a clear.
- R11: While `run` is low and the load word is not written, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = full-width real-time-clock mode, 0 = half-width modes |
| mode | input | 2 | Half-width job: 00 one-shot, 01 periodic, 10 PWM, 11 edge count |
| run | input | 1 | Counter enable |
| edge_in | input | 1 | Asynchronous input whose rising edges are counted |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 2*HALF_W | Write data |
| rdata | output | 2*HALF_W | Read data for `addr` |
| flag | output | 1 | Sticky match/timeout status |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with HALF_W = 4 and PS_W = 3, an 8-bit full counter and a 3-bit prescaler. At these sizes every load/prescale pair for the one-shot and periodic periods can be swept. So can every load/match pair for PWM high time and edge-count stop point, and all 256 real-time-clock match values. Each expected value comes from the period and duty formulas rather than from traced waveforms.

// File: rtl/mm_match_timer.sv
module mm_match_timer #(
  parameter int HALF_W = 16,
  parameter int PS_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_mode,
  input  logic [1:0]            mode,
  input  logic                  run,
  input  logic                  edge_in,
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0]   rdata,
  output logic                  flag,
  output logic                  pwm_out
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [1:0] M_ONE = 2'b00, M_PER = 2'b01, M_PWM = 2'b10, M_EDGE = 2'b11;
  localparam logic [FULL_W-1:0] NARROW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [FULL_W-1:0] cnt, ld, mr, nxt;
  logic [PS_W-1:0]   ps, pc;
  logic [2:0]        sy;
  logic              hit, tick;

  wire [FULL_W-1:0] act_mask = wide_mode ? {FULL_W{1'b1}} : NARROW_MASK;
  wire [FULL_W-1:0] mr_eff   = mr & act_mask;
  wire [FULL_W-1:0] wd_m     = wdata & act_mask;
  wire ld_wr      = wr_en && addr == 2'd0;
  wire clr        = wr_en && addr == 2'd3 && wdata[0];
  wire presc_mode = !wide_mode && !mode[1];
  wire rise       = sy[1] & ~sy[2];

  always_comb begin
    nxt = cnt;
    hit = 1'b0;
    if (wide_mode) begin
      nxt = cnt + 1'b1;
      hit = (cnt == mr);
    end else begin
      case (mode)
        M_ONE: begin
          if (cnt != '0) nxt = cnt - 1'b1;
          hit = (cnt == FULL_W'(1));
        end
        M_PER, M_PWM: begin
          nxt = (cnt == '0) ? ld : cnt - 1'b1;
          hit = (cnt == '0);
        end
        default: begin
          nxt = (cnt - 1'b1) & act_mask;
          hit = (((cnt - 1'b1) & act_mask) == mr_eff);
        end
      endcase
    end
  end

  always_comb begin
    if (!run)                          tick = 1'b0;
    else if (presc_mode)               tick = (pc == '0);
    else if (!wide_mode && mode == M_EDGE) tick = rise && (cnt != mr_eff);
    else                               tick = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      ld   <= '0;
      mr   <= wide_mode ? {FULL_W{1'b1}} : NARROW_MASK;
      ps   <= '0;
      pc   <= '0;
      sy   <= '0;
      flag <= 1'b0;
    end else begin
      sy <= {sy[1:0], edge_in};
      if (wr_en && addr == 2'd1) mr <= wdata;
      if (wr_en && addr == 2'd2) ps <= wdata[PS_W-1:0];
      flag <= (tick && hit && !ld_wr) | (flag & ~clr);
      if (ld_wr) begin
        ld  <= wd_m;
        cnt <= wd_m;
        pc  <= ps;
      end else begin
        if (tick) cnt <= nxt;
        if (presc_mode && run) pc <= (pc == '0) ? ps : pc - 1'b1;
      end
    end
  end

  assign pwm_out = run && !wide_mode && mode == M_PWM && (cnt > mr_eff);

  always_comb begin
    case (addr)
      2'd0:    rdata = ld;
      2'd1:    rdata = mr_eff;
      2'd2:    rdata = {{(FULL_W-PS_W){1'b0}}, ps};
      default: rdata = cnt;
    endcase
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_wr) |=> $stable(cnt));
  p_oneshot_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && mode == M_ONE && cnt == '0 && !ld_wr) |=> (cnt == '0));
  p_edge_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && mode == M_EDGE && cnt == mr_eff && !ld_wr) |=> $stable(cnt));
  p_rtc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && run && !ld_wr) |=> (cnt == FULL_W'($past(cnt) + 1'b1)));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: tb/mm_match_timer_bench.sv
`timescale 1ns/1ps
module mm_match_timer_bench;
  localparam int HW = 4;
  localparam int FW = 2 * HW;

  logic clk = 1'b0, rst_n = 1'b0, wide = 1'b0, run = 1'b0, edge_in = 1'b0, wr = 1'b0;
  logic [1:0] mode = 2'b00, addr = 2'b00;
  logic [FW-1:0] wdata = '0;
  wire  [FW-1:0] rdata;
  wire flag, pwm;
  int n_chk = 0, n_fail = 0;

  mm_match_timer #(.HALF_W(HW), .PS_W(3)) u_mm_match_timer (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide), .mode(mode), .run(run),
    .edge_in(edge_in), .wr_en(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .flag(flag), .pwm_out(pwm));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input int d);
    wr = 1'b1; addr = a; wdata = FW'(d);
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic do_reset(input logic w);
    wide = w; rst_n = 1'b0; run = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!flag && n < 400) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, n, n2;
    do_reset(1'b0);
    rd_reg(2'd0, v); chk("R1 load reset", v, 0);
    rd_reg(2'd1, v); chk("R1 narrow match reset", v, 15);
    rd_reg(2'd2, v); chk("R1 prescale reset", v, 0);
    rd_reg(2'd3, v); chk("R1 count reset", v, 0);
    chk("R1 flag reset", int'(flag), 0);
    chk("R1 pwm reset", int'(pwm), 0);

    wr_reg(2'd2, 8'hFD); rd_reg(2'd2, v); chk("R3 prescale readback", v, 5);
    wr_reg(2'd2, 8'h02); rd_reg(2'd2, v); chk("R3 prescale readback", v, 2);
    wr_reg(2'd1, 8'hA3); rd_reg(2'd1, v); chk("R2 narrow match upper zero", v, 3);

    // R11: count holds while run is low
    mode = 2'b01; wr_reg(2'd0, 9);
    repeat (10) @(negedge clk);
    rd_reg(2'd3, v); chk("R11 hold while stopped", v, 9);

    // R4 / R5: period sweep over all load and prescale values
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m);
      for (int ld = 0; ld < 16; ld++) begin
        for (int p = 0; p < 8; p++) begin
          run = 1'b0;
          wr_reg(2'd2, p); wr_reg(2'd0, ld); wr_reg(2'd3, 1);
          run = 1'b1;
          wait_flag(n);
          if (m == 0) begin
            if (ld == 0) chk("R4 one-shot from zero never flags", int'(flag), 0);
            else begin
              chk("R4 one-shot delay", n, ld * (p + 1));
              repeat (5) @(negedge clk);
              rd_reg(2'd3, v); chk("R4 one-shot stays at zero", v, 0);
            end
          end else begin
            chk("R5 periodic first period", n, (ld + 1) * (p + 1));
            if ((ld + 1) * (p + 1) >= 3) begin
              wr_reg(2'd3, 1);
              n2 = 1;
              while (!flag && n2 < 400) begin
                @(posedge clk); n2++; @(negedge clk);
              end
              chk("R5 periodic reload period", n2, (ld + 1) * (p + 1));
            end
          end
        end
      end
    end

    // R10: status clear semantics
    run = 1'b0; mode = 2'b00; wr_reg(2'd0, 1); run = 1'b1;
    repeat (12) @(negedge clk); run = 1'b0;
    chk("R10 flag set", int'(flag), 1);
    wr_reg(2'd3, 0); chk("R10 write 0 keeps flag", int'(flag), 1);
    wr_reg(2'd3, 1); chk("R10 write 1 clears flag", int'(flag), 0);

    // R8 / R6: PWM high time, prescale left at 5 to show it is ignored
    mode = 2'b10; wr_reg(2'd2, 5);
    for (int ld = 1; ld < 16; ld++) begin
      for (int mr = 0; mr < 16; mr++) begin
        run = 1'b0;
        wr_reg(2'd1, mr); wr_reg(2'd0, ld);
        run = 1'b1; #1;
        n = 0;
        for (int i = 0; i < 2 * (ld + 1); i++) begin
          if (pwm) n++;
          @(posedge clk); @(negedge clk);
        end
        chk("R8 R6 pwm high clocks over two periods", n, (mr < ld) ? 2 * (ld - mr) : 0);
      end
    end
    run = 1'b0; #1; chk("R8 pwm low when stopped", int'(pwm), 0);

    // R9 / R6: edge-count stop point
    mode = 2'b11; wr_reg(2'd2, 3);
    for (int ld = 0; ld < 16; ld++) begin
      for (int mr = 0; mr <= ld; mr++) begin
        run = 1'b0;
        wr_reg(2'd1, mr); wr_reg(2'd0, ld); wr_reg(2'd3, 1);
        run = 1'b1;
        repeat (ld - mr + 2) begin
          edge_in = 1'b1; repeat (3) @(negedge clk);
          edge_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        run = 1'b0;
        rd_reg(2'd3, v); chk("R9 edge count stops at match", v, mr);
        chk("R9 edge count flag", int'(flag), (ld != mr) ? 1 : 0);
      end
    end
    // R2: upper match bits ignored in narrow compare
    run = 1'b0; wr_reg(2'd1, 8'hF2); wr_reg(2'd0, 5); wr_reg(2'd3, 1); run = 1'b1;
    repeat (6) begin
      edge_in = 1'b1; repeat (3) @(negedge clk);
      edge_in = 1'b0; repeat (3) @(negedge clk);
    end
    run = 1'b0; repeat (4) @(negedge clk);
    rd_reg(2'd3, v); chk("R2 narrow compare uses low half", v, 2);

    // R1 / R7: wide reset and real-time-clock match sweep
    do_reset(1'b1);
    rd_reg(2'd1, v); chk("R1 wide match reset", v, 255);
    wr_reg(2'd1, 8'hA3); rd_reg(2'd1, v); chk("R2 wide match full width", v, 163);
    wr_reg(2'd2, 7);
    for (int m = 0; m < 256; m++) begin
      run = 1'b0;
      wr_reg(2'd1, m); wr_reg(2'd0, 0); wr_reg(2'd3, 1);
      run = 1'b1;
      wait_flag(n);
      chk("R7 R6 rtc match clock", n, m + 1);
    end
    run = 1'b0; wr_reg(2'd1, 8'h37); wr_reg(2'd0, 8'h30); wr_reg(2'd3, 1); run = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg(2'd3, v); chk("R7 rtc counts up", v, 8'h35);
    run = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule